// File: doc/BRIEF.md
# Two-Accumulator Execution Unit with Condition Codes

This unit is the arithmetic back end of a small 8-bit core. It has two accumulators, A and B. Read together, they form a 16-bit pair D, with A as the upper byte. A four-flag condition-code register sits beside them. A start pulse carries an opcode into the unit. The unit then shifts, decrements, multiplies, transfers or idles, and it reports completion through a busy/done handshake after a fixed cycle count for each opcode.

The surrounding core writes operands into the pair through a load strobe while the unit is idle. It then issues an opcode and waits for done. The results and flags become visible on the cycle after done. The unit does not fetch instructions, compute addresses or access memory.

Top module: `acc_alu`

## Requirements
- R1: While rst_ni is low, and on the first cycle after rst_ni rises, A, B and the CCR read as zero and busy_o and done_o are low.
- R2: A start_i accepted while idle raises busy_o from the next cycle for exactly the opcode's cycle count, and done_o is high only in the last busy cycle. A start_i seen while busy_o is high is ignored. A, B and the CCR change only at the end of a done cycle or through a load.
- R3: ld_en_i while idle writes ld_data_i[15:8] into A and ld_data_i[7:0] into B, and leaves the flags unchanged. ld_en_i while busy_o is high has no effect.
- R4: Opcode 0x48 shifts A left by one and 0x58 shifts B left by one, each in 2 cycles. A zero enters at bit 0. C takes the old bit 7, N and Z follow the 8-bit result, and V = N XOR C.
- R5: Opcode 0x4A decrements A and 0x5A decrements B, modulo 256, each in 2 cycles. N and Z follow the result, V is set only if the operand was 0x80, and C is kept.
- R6: Opcode 0x3D takes 3 cycles and puts the unsigned product A*B into D, with the high byte in A and the low byte in B. C becomes bit 7 of the new B, and N, Z and V are kept.
- R7: Opcode 0x17 copies B into A in 2 cycles. N and Z follow the copied value, V is cleared and C is kept.
- R8: Opcode 0x01 completes in 2 cycles and any other unlisted opcode completes in 1 cycle. Neither changes A, B or the CCR.
- R9: ccr_o carries N in bit 3, Z in bit 2, V in bit 1 and C in bit 0, and bits 7:4 always read zero.
- R10: A load and a start in the same idle cycle both take effect: the operation acts on the freshly loaded operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin the operation in opcode_i |
| opcode_i | input | 8 | Operation select |
| ld_en_i | input | 1 | Write ld_data_i into the accumulator pair |
| ld_data_i | input | 16 | Value for the pair: A is the upper byte, B the lower |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Last cycle of the operation |
| acc_a_o | output | 8 | Accumulator A |
| acc_b_o | output | 8 | Accumulator B |
| ccr_o | output | 8 | Condition codes {0000,N,Z,V,C} |

## Verification
Operand loading and operation start can coincide in two ways. Both may arrive in the same idle cycle, or a load or a second start may arrive while an operation is still busy. The bench provokes the first case by asserting ld_en_i and start_i together with a multiply. It provokes the second by injecting a start or a load in the first busy cycle of a multiply and of a decrement. Each case is judged by the final A, B and CCR and by the measured busy length. Coinciding inputs must either act on the loaded operands or leave no trace at all.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam logic [7:0] OP_NOP  = 8'h01;
  localparam logic [7:0] OP_TBA  = 8'h17;
  localparam logic [7:0] OP_MUL  = 8'h3D;
  localparam logic [7:0] OP_ASLA = 8'h48;
  localparam logic [7:0] OP_DECA = 8'h4A;
  localparam logic [7:0] OP_ASLB = 8'h58;
  localparam logic [7:0] OP_DECB = 8'h5A;

  localparam int unsigned MAX_CYC = 3;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } flags_t;

  function automatic int unsigned op_cycles(logic [7:0] op);
    case (op)
      OP_MUL:                                         return 3;
      OP_NOP, OP_TBA, OP_ASLA, OP_ASLB, OP_DECA, OP_DECB: return 2;
      default:                                        return 1;
    endcase
  endfunction
endpackage

// File: rtl/acc_alu_seq.sv
module acc_alu_seq
  import acc_alu_pkg::*;
#(
  parameter int unsigned CNT_W = $clog2(MAX_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       start_i,
  input  logic [7:0] opcode_i,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] op_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       op_q;

  assign busy_o = (cnt_q != '0);
  assign done_o = (cnt_q == CNT_W'(1));
  assign op_o   = op_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      op_q  <= '0;
    end else if (start_i && !busy_o) begin
      cnt_q <= CNT_W'(op_cycles(opcode_i));
      op_q  <= opcode_i;
    end else if (busy_o) begin
      cnt_q <= cnt_q - CNT_W'(1);
    end
  end
endmodule

// File: rtl/acc_alu_exec.sv
module acc_alu_exec
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic [7:0]    op_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  input  flags_t        flags_i,
  output logic [DW-1:0] a_o,
  output logic [DW-1:0] b_o,
  output flags_t        flags_o
);
  localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};

  logic [DW-1:0]   src;
  logic [DW-1:0]   res;
  logic [2*DW-1:0] prod;

  // shift/decrement share one operand mux
  assign src  = (op_i == OP_ASLB || op_i == OP_DECB) ? b_i : a_i;
  assign prod = {{DW{1'b0}}, a_i} * {{DW{1'b0}}, b_i};

  always_comb begin
    a_o     = a_i;
    b_o     = b_i;
    flags_o = flags_i;
    res     = '0;
    case (op_i)
      OP_ASLA, OP_ASLB: begin
        res       = {src[DW-2:0], 1'b0};
        flags_o.c = src[DW-1];
        flags_o.n = res[DW-1];
        flags_o.z = (res == '0);
        flags_o.v = res[DW-1] ^ src[DW-1];
      end
      OP_DECA, OP_DECB: begin
        res       = src - DW'(1);
        flags_o.n = res[DW-1];
        flags_o.z = (res == '0);
        flags_o.v = (src == MSB_ONLY);
      end
      OP_TBA: begin
        res       = b_i;
        flags_o.n = b_i[DW-1];
        flags_o.z = (b_i == '0);
        flags_o.v = 1'b0;
      end
      OP_MUL: begin
        flags_o.c = prod[DW-1];
      end
      default: ;
    endcase
    case (op_i)
      OP_ASLA, OP_DECA, OP_TBA: a_o = res;
      OP_ASLB, OP_DECB:         b_o = res;
      OP_MUL: begin
        a_o = prod[2*DW-1:DW];
        b_o = prod[DW-1:0];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [7:0]    opcode_i,
  input  logic          ld_en_i,
  input  logic [2*DW-1:0] ld_data_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] acc_a_o,
  output logic [DW-1:0] acc_b_o,
  output logic [7:0]    ccr_o
);
  logic [DW-1:0] a_q, b_q, a_nx, b_nx;
  flags_t        flg_q, flg_nx;
  logic          busy, done;
  logic [7:0]    op_q;

  acc_alu_seq u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .opcode_i (opcode_i),
    .busy_o   (busy),
    .done_o   (done),
    .op_o     (op_q)
  );

  acc_alu_exec #(.DW(DW)) u_exec (
    .op_i    (op_q),
    .a_i     (a_q),
    .b_i     (b_q),
    .flags_i (flg_q),
    .a_o     (a_nx),
    .b_o     (b_nx),
    .flags_o (flg_nx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q   <= '0;
      b_q   <= '0;
      flg_q <= '0;
    end else if (done) begin
      a_q   <= a_nx;
      b_q   <= b_nx;
      flg_q <= flg_nx;
    end else if (ld_en_i && !busy) begin
      a_q <= ld_data_i[2*DW-1:DW];
      b_q <= ld_data_i[DW-1:0];
    end
  end

  assign busy_o  = busy;
  assign done_o  = done;
  assign acc_a_o = a_q;
  assign acc_b_o = b_q;
  assign ccr_o   = {4'b0000, flg_q};
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          ld_en_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [DW-1:0] acc_a_o,
  input logic [DW-1:0] acc_b_o,
  input logic [7:0]    ccr_o,
  input logic [7:0]    op_q
);
  localparam logic [DW-1:0] MSB_ONLY = {1'b1, {(DW-1){1'b0}}};

  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R2
  AST_DONE_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o); // R2
  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> busy_o); // R2
  AST_STATE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!done_o && !(ld_en_i && !busy_o)) |=>
      ($stable(acc_a_o) && $stable(acc_b_o) && $stable(ccr_o))); // R2
  AST_LOAD_KEEPS_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_en_i && !busy_o) |=> $stable(ccr_o)); // R3
  AST_ASL_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && (op_q == OP_ASLA || op_q == OP_ASLB)) |=>
      (ccr_o[1] == (ccr_o[3] ^ ccr_o[0]))); // R4
  AST_DEC_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_DECA) |=>
      (ccr_o[1] == ($past(acc_a_o) == MSB_ONLY) && ccr_o[0] == $past(ccr_o[0]))); // R5
  AST_MUL_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_MUL) |=>
      (ccr_o[0] == acc_b_o[DW-1] && ccr_o[3:1] == $past(ccr_o[3:1]))); // R6
  AST_TRANSFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && op_q == OP_TBA) |=> (acc_a_o == acc_b_o && !ccr_o[1])); // R7
  AST_CCR_HIGH_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ccr_o[7:4] == 4'b0000); // R9
endmodule

bind acc_alu acc_alu_chk #(.DW(DW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .start_i (start_i),
  .ld_en_i (ld_en_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .acc_a_o (acc_a_o),
  .acc_b_o (acc_b_o),
  .ccr_o   (ccr_o),
  .op_q    (op_q)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [7:0]  opcode_i = 8'h00;
  logic        ld_en_i = 1'b0;
  logic [15:0] ld_data_i = 16'h0000;
  logic        busy_o, done_o;
  logic [7:0]  acc_a_o, acc_b_o, ccr_o;

  int total = 0;
  int bad = 0;
  int cyc_cnt = 0;

  always #2 clk_i = ~clk_i;

  acc_alu u_acc_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .opcode_i(opcode_i),
    .ld_en_i(ld_en_i), .ld_data_i(ld_data_i), .busy_o(busy_o), .done_o(done_o),
    .acc_a_o(acc_a_o), .acc_b_o(acc_b_o), .ccr_o(ccr_o)
  );

  // {op, load, expA, expB, expCCR, cycles, req}
  localparam int NVEC = 15;
  localparam logic [55:0] VEC [NVEC] = '{
    {8'h48, 16'h8100, 8'h02, 8'h00, 8'h03, 4'd2, 4'd4},  // R4 carry out, V set
    {8'h58, 16'h0040, 8'h00, 8'h80, 8'h0A, 4'd2, 4'd4},  // R4 N without C
    {8'h48, 16'hC000, 8'h80, 8'h00, 8'h09, 4'd2, 4'd4},  // R4 N and C, V clear
    {8'h58, 16'h0080, 8'h00, 8'h00, 8'h07, 4'd2, 4'd4},  // R4 zero result
    {8'h4A, 16'h8000, 8'h7F, 8'h00, 8'h03, 4'd2, 4'd5},  // R5 0x80 overflow, C kept
    {8'h5A, 16'h0001, 8'h00, 8'h00, 8'h05, 4'd2, 4'd5},  // R5 to zero
    {8'h4A, 16'h0000, 8'hFF, 8'h00, 8'h09, 4'd2, 4'd5},  // R5 wrap
    {8'h3D, 16'hFFFF, 8'hFE, 8'h01, 8'h08, 4'd3, 4'd6},  // R6 max product
    {8'h3D, 16'h1010, 8'h01, 8'h00, 8'h08, 4'd3, 4'd6},  // R6 low byte zero
    {8'h3D, 16'h0C0B, 8'h00, 8'h84, 8'h09, 4'd3, 4'd6},  // R6 C from B bit 7
    {8'h17, 16'h0080, 8'h80, 8'h80, 8'h09, 4'd2, 4'd7},  // R7 negative copy
    {8'h17, 16'hFF00, 8'h00, 8'h00, 8'h05, 4'd2, 4'd7},  // R7 zero copy
    {8'h01, 16'h1234, 8'h12, 8'h34, 8'h05, 4'd2, 4'd8},  // R8 no-op
    {8'hFF, 16'h5678, 8'h56, 8'h78, 8'h05, 4'd1, 4'd8},  // R8 unlisted opcode
    {8'h5A, 16'h0020, 8'h00, 8'h1F, 8'h01, 4'd2, 4'd5}   // R5 plain decrement
  };

  task automatic check(input bit ok, input int req, input logic [15:0] act,
                       input logic [15:0] exp, input string what);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] d);
    @(negedge clk_i);
    ld_en_i = 1'b1; ld_data_i = d;
    @(negedge clk_i);
    ld_en_i = 1'b0;
  endtask

  // inject: 0 none, 1 start during busy, 2 load during busy, 3 load with start
  task automatic run_op(input logic [7:0] op, input int inject, output int n_busy,
                        output int done_at);
    @(negedge clk_i);
    start_i = 1'b1; opcode_i = op;
    if (inject == 3) begin ld_en_i = 1'b1; ld_data_i = 16'h0302; end
    @(negedge clk_i);
    start_i = 1'b0; ld_en_i = 1'b0;
    n_busy = 0; done_at = 0;
    while (busy_o && n_busy < 16) begin
      n_busy++;
      if (done_o) done_at = n_busy;
      if (n_busy == 1 && inject == 1) begin start_i = 1'b1; opcode_i = 8'h48; end
      if (n_busy == 1 && inject == 2) begin ld_en_i = 1'b1; ld_data_i = 16'hAAAA; end
      @(negedge clk_i);
      start_i = 1'b0; ld_en_i = 1'b0;
    end
  endtask

  always @(posedge clk_i) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      bad++; total++;
      $display("FAIL R2 watchdog: actual %0d expected %0d", cyc_cnt, 100000);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [55:0] v;
    int nb, da;
    repeat (3) @(negedge clk_i);
    check(acc_a_o == 0 && acc_b_o == 0 && ccr_o == 0 && !busy_o && !done_o, 1,
          {acc_a_o, ccr_o}, 16'h0, "R1 state in reset");
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(acc_a_o == 0 && acc_b_o == 0 && ccr_o == 0 && !busy_o, 1,
          {acc_b_o, ccr_o}, 16'h0, "R1 state after reset");

    for (int i = 0; i < NVEC; i++) begin
      v = VEC[i];
      do_load(v[47:32]);
      run_op(v[55:48], 0, nb, da);
      check(nb == int'(v[7:4]) && da == int'(v[7:4]), int'(v[3:0]),
            16'(nb), 16'(v[7:4]), "R2 busy length");
      check(acc_a_o == v[31:24] && acc_b_o == v[23:16], int'(v[3:0]),
            {acc_a_o, acc_b_o}, v[31:16], "result A:B");
      check(ccr_o == v[15:8], int'(v[3:0]), 16'(ccr_o), 16'(v[15:8]),
            "R9 flags");
    end

    // R2: start during busy ignored
    do_load(16'h0506);
    check(ccr_o == 8'h01, 3, 16'(ccr_o), 16'h01, "R3 load keeps flags");
    run_op(8'h3D, 1, nb, da);
    check(nb == 3 && da == 3, 2, 16'(nb), 16'd3, "start while busy");
    check({acc_a_o, acc_b_o} == 16'h001E && ccr_o == 8'h00, 2,
          {acc_b_o, ccr_o}, 16'h1E00, "start while busy result");
    @(negedge clk_i);
    check(!busy_o && acc_b_o == 8'h1E, 2, 16'(acc_b_o), 16'h1E, "no late op");

    // R3: load during busy ignored
    do_load(16'h8000);
    run_op(8'h4A, 2, nb, da);
    check({acc_a_o, acc_b_o} == 16'h7F00 && ccr_o == 8'h02, 3,
          {acc_a_o, acc_b_o}, 16'h7F00, "load while busy");

    // R10: load and start together
    run_op(8'h3D, 3, nb, da);
    check({acc_a_o, acc_b_o} == 16'h0006 && ccr_o == 8'h02 && nb == 3, 10,
          {acc_a_o, acc_b_o}, 16'h0006, "load with start");
    check(ccr_o[7:4] == 4'h0, 9, 16'(ccr_o), 16'h02, "R9 upper bits");

    // R1: reset again mid-life
    @(negedge clk_i);
    rst_ni = 1'b0;
    @(negedge clk_i);
    check(acc_b_o == 0 && ccr_o == 0 && !busy_o, 1, {acc_b_o, ccr_o}, 16'h0,
          "R1 second reset");
    rst_ni = 1'b1;

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule